// File: doc/BRIEF.md
# Physical-Address Word Transfer Unit

This unit moves one 16-bit word between a register pair and a 20-bit physical byte memory. No logical-to-physical translation is applied. A 4-bit bank value, taken from the low nibble of the accumulator, forms address bits 19:16. A 16-bit pointer, chosen upstream from HL, IX, IY or an immediate, forms bits 15:0. The transfer runs as two sequential byte accesses, low byte first.

The second byte address is the pointer plus one, computed in 16 bits only. A word whose pointer is 0xFFFF therefore splits between the top and the bottom of the same 64K page, and the bank never advances. On a load the two bytes are gathered into the 16-bit result. On a store the low and high bytes of the store word go out in the same order.

Each transfer takes ten clocks, made up of five two-clock phases. A busy flag covers all ten clocks. A one-cycle done pulse follows. The memory port is byte wide and synchronous, and read data arrives one cycle after the address.

Top module: `phys_word_xfer`

## Requirements
- R1: The first byte access of a transfer uses address {bank, pointer}. The bank and the pointer are the values sampled in the cycle the start is accepted.
- R2: The second byte access uses address {bank, (pointer + 1) mod 65536}. A pointer of 0xFFFF in bank n reaches n:0x0000 and never (n+1):0x0000.
- R3: After a load, ld_data_o[7:0] holds the byte read at the first address and ld_data_o[15:8] holds the byte read at the second address. The value is visible from the done cycle and holds until the next load completes.
- R4: A store drives mem_we_o high on both of its accesses, with st_data_i[7:0] on the first access and st_data_i[15:8] on the second. A load never drives mem_we_o high.
- R5: An accepted start (start_i high while busy_o is low at a clock edge) makes busy_o high for exactly 10 cycles. done_o is then high for exactly the one cycle after busy_o falls.
- R6: Each transfer makes exactly two memory accesses (mem_en_o high). They fall in the 3rd and 7th busy cycles, which are busy cycle indices 2 and 6 counted from 0.
- R7: While busy_o is high, start_i is ignored, and changes on store_i, ptr_i, bank_i or st_data_i have no effect on the running transfer.
- R8: Reset is synchronous and active high. It clears busy_o, done_o, mem_en_o and mem_we_o, and sets ld_data_o to zero.
- R9: A store leaves ld_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a transfer |
| store_i | input | 1 | 1 = store word, 0 = load word |
| ptr_i | input | 16 | Pointer, address bits 15:0 |
| bank_i | input | 4 | Accumulator low nibble, address bits 19:16 |
| st_data_i | input | 16 | Word to store |
| ld_data_o | output | 16 | Loaded word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, valid one cycle after the access |

## Verification
Loads are tried with ordinary pointers, with pointer 0xFFFF and with pointer 0x0000 in several banks. Unwritten bytes return a value derived from their full 20-bit address, so a carry into the bank, a swapped byte order or a reused address each give a wrong word. Store-then-load pairs across the page edge show whether the wrapped byte lands in the right place and whether the next bank is untouched. During noisy transfers every input changes and start is held high through the busy window, which separates correctly latched operands from live ones. Long runs with start held high test back-to-back acceptance just after done.

// File: rtl/phys_xfer_pkg.sv
package phys_xfer_pkg;
  localparam int XFER_BYTE_W = 8;
  typedef enum logic {XFER_LOAD = 1'b0, XFER_STORE = 1'b1} xfer_dir_e;
endpackage

// File: rtl/phys_xfer_addr.sv
// Builds one physical address per byte lane; the pointer increment is kept
// to PTR_W bits so a word never leaves its page.
module phys_xfer_addr #(
  parameter int BANK_W = 4,
  parameter int PTR_W  = 16,
  parameter int BYTES  = 2,
  localparam int ADDR_W = BANK_W + PTR_W
) (
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [PTR_W-1:0]              ptr_i,
  output logic [BYTES-1:0][ADDR_W-1:0]  addr_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [PTR_W-1:0] off;
    assign off       = ptr_i + PTR_W'(k);
    assign addr_o[k] = {bank_i, off};
  end
endmodule

// File: rtl/phys_xfer_seq.sv
// Cycle sequencer: a busy window of TOTAL clocks, one access slot per byte
// lane at odd phase boundaries, and a capture strobe one cycle after each.
module phys_xfer_seq #(
  parameter int TOTAL      = 10,
  parameter int BYTES      = 2,
  parameter int PHASE_CLKS = 2,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output logic [BYTES-1:0] slot_o,
  output logic [BYTES-1:0] cap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  for (genvar k = 0; k < BYTES; k++) begin : g_slot
    // access k is on the bus when cnt = PHASE_CLKS*(2k+1); registered one earlier
    assign slot_o[k] = busy_q && (cnt_q == CNT_W'(PHASE_CLKS * (2 * k + 1) - 1));
    assign cap_o[k]  = busy_q && (cnt_q == CNT_W'(PHASE_CLKS * (2 * k + 1) + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: busy window is not cut short
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != LAST) |=> busy_q);
  // R5: done is a single-cycle pulse following the end of busy
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/phys_word_xfer.sv
module phys_word_xfer #(
  parameter int BANK_W     = 4,
  parameter int PTR_W      = 16,
  parameter int BYTES      = 2,
  parameter int PHASES     = 5,
  parameter int PHASE_CLKS = 2,
  localparam int BYTE_W = phys_xfer_pkg::XFER_BYTE_W,
  localparam int DATA_W = BYTES * BYTE_W,
  localparam int ADDR_W = BANK_W + PTR_W,
  localparam int TOTAL  = PHASES * PHASE_CLKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              store_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  import phys_xfer_pkg::*;

  logic                            accept;
  logic [BYTES-1:0]                slot, cap;
  logic [BANK_W-1:0]               bank_q;
  logic [PTR_W-1:0]                ptr_q;
  logic [DATA_W-1:0]               wdata_q, load_q;
  xfer_dir_e                       dir_q;
  logic [BYTES-1:0][ADDR_W-1:0]    lane_addr;
  logic                            en_q, we_q;
  logic [ADDR_W-1:0]               addr_q;
  logic [BYTE_W-1:0]               wbyte_q;

  phys_xfer_seq #(.TOTAL(TOTAL), .BYTES(BYTES), .PHASE_CLKS(PHASE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .accept_o(accept),
    .slot_o(slot), .cap_o(cap)
  );

  phys_xfer_addr #(.BANK_W(BANK_W), .PTR_W(PTR_W), .BYTES(BYTES)) u_addr (
    .bank_i(bank_q), .ptr_i(ptr_q), .addr_o(lane_addr)
  );

  // operand capture at acceptance only
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      dir_q   <= XFER_LOAD;
    end else if (accept) begin
      bank_q  <= bank_i;
      ptr_q   <= ptr_i;
      wdata_q <= st_data_i;
      dir_q   <= store_i ? XFER_STORE : XFER_LOAD;
    end
  end

  // registered memory port, lane order low to high
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wbyte_q <= '0;
    end else begin
      en_q <= 1'b0;
      we_q <= 1'b0;
      for (int k = 0; k < BYTES; k++) begin
        if (slot[k]) begin
          en_q    <= 1'b1;
          we_q    <= (dir_q == XFER_STORE);
          addr_q  <= lane_addr[k];
          wbyte_q <= wdata_q[k*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  // load assembly: read byte k arrives the cycle after access k
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
    end else if (dir_q == XFER_LOAD) begin
      for (int k = 0; k < BYTES; k++) begin
        if (cap[k]) load_q[k*BYTE_W +: BYTE_W] <= mem_rdata_i;
      end
    end
  end

  assign mem_en_o    = en_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wbyte_q;
  assign ld_data_o   = load_q;

  // R6: accesses only inside a transfer
  a_r6_access_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> busy_o);
  // R4: writes only for stores
  a_r4_write_is_store: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_en_o && dir_q == XFER_STORE));
  // R2: every access stays in the latched bank
  a_r2_bank_fixed: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> (mem_addr_o[ADDR_W-1:PTR_W] == bank_q));
  // R7: operands stay put while busy
  a_r7_operands_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(ptr_q) && $stable(bank_q) && $stable(wdata_q)));
  // R9: a store does not disturb the load result
  a_r9_store_keeps_load: assert property (@(posedge clk) disable iff (rst)
    (busy_o && dir_q == XFER_STORE) |=> $stable(ld_data_o));
endmodule

// File: tb/sim_phys_word_xfer.sv
module sim_phys_word_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_LEN   = 10;
  localparam int ACC0       = 2;
  localparam int ACC1       = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, store_i = 1'b0;
  logic [15:0] ptr_i = '0, st_data_i = '0;
  logic [3:0]  bank_i = '0;
  logic [15:0] ld_data_o;
  logic        busy_o, done_o, mem_en_o, mem_we_o;
  logic [19:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phys_word_xfer u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .store_i(store_i), .ptr_i(ptr_i),
    .bank_i(bank_i), .st_data_i(st_data_i), .ld_data_o(ld_data_o),
    .busy_o(busy_o), .done_o(done_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  // environment memory: unwritten bytes return a hash of the full address
  logic [7:0] mem [int];
  function automatic logic [7:0] rd(input logic [19:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
      else          mem_rdata <= rd(mem_addr_o);
    end
  end

  // behavioural reference model
  int          ph = -1;
  logic        m_done = 1'b0, m_store = 1'b0;
  logic [3:0]  m_bank = '0;
  logic [15:0] m_ptr = '0, m_wd = '0, m_load = '0;

  function automatic logic [19:0] exp_addr(input int lane);
    logic [15:0] p;
    p = m_ptr + 16'(lane);
    return {m_bank, p};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = -1; m_done = 1'b0; m_load = '0;
    end else begin
      m_done = 1'b0;
      if (ph < 0) begin
        if (start_i) begin
          m_store = store_i; m_bank = bank_i; m_ptr = ptr_i; m_wd = st_data_i; ph = 0;
        end
      end else if (ph == BUSY_LEN - 1) begin
        ph = -1; m_done = 1'b1;
        if (!m_store) m_load = {rd(exp_addr(1)), rd(exp_addr(0))};
      end else begin
        ph = ph + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(busy_o == (ph >= 0), "R5 busy", int'(busy_o), int'(ph >= 0));
      chk(done_o == m_done, "R5 done", int'(done_o), int'(m_done));
      chk(mem_en_o == (ph == ACC0 || ph == ACC1), "R6 access slot", int'(mem_en_o),
          int'(ph == ACC0 || ph == ACC1));
      if (ph == ACC0) begin
        chk(mem_addr_o == exp_addr(0), "R1 first address", int'(mem_addr_o), int'(exp_addr(0)));
        chk(mem_we_o == m_store, "R4 we first", int'(mem_we_o), int'(m_store));
        if (m_store) chk(mem_wdata_o == m_wd[7:0], "R4 low byte", int'(mem_wdata_o), int'(m_wd[7:0]));
      end
      if (ph == ACC1) begin
        chk(mem_addr_o == exp_addr(1), "R2 second address", int'(mem_addr_o), int'(exp_addr(1)));
        chk(mem_we_o == m_store, "R4 we second", int'(mem_we_o), int'(m_store));
        if (m_store) chk(mem_wdata_o == m_wd[15:8], "R4 high byte", int'(mem_wdata_o), int'(m_wd[15:8]));
      end
      if (ph < 0)
        chk(ld_data_o == m_load, "R3/R9 load result", int'(ld_data_o), int'(m_load));
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // one transfer; noisy keeps start high and scrambles inputs while busy (R7)
  task automatic run_op(input logic st, input logic [3:0] bk, input logic [15:0] p,
                        input logic [15:0] wd, input bit noisy);
    @(negedge clk);
    start_i = 1'b1; store_i = st; bank_i = bk; ptr_i = p; st_data_i = wd;
    for (int i = 0; i < BUSY_LEN; i++) begin
      @(negedge clk);
      start_i = noisy && (i < BUSY_LEN - 1);
      if (noisy) begin
        store_i = ~store_i; bank_i = bank_i + 4'd7;
        ptr_i = ptr_i ^ 16'h3C5A; st_data_i = st_data_i + 16'h1111;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin : stim
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8 busy/done", int'({busy_o, done_o}), 0);
    chk(mem_en_o == 1'b0 && mem_we_o == 1'b0, "R8 mem strobes", int'({mem_en_o, mem_we_o}), 0);
    chk(ld_data_o == 16'h0, "R8 load zero", int'(ld_data_o), 0);
    rst = 1'b0;
    run_op(1'b0, 4'h3, 16'h1234, 16'h0, 1'b0);   // plain load R1 R3
    run_op(1'b0, 4'h5, 16'hFFFF, 16'h0, 1'b0);   // page wrap load R2
    run_op(1'b1, 4'h5, 16'hFFFF, 16'hBEEF, 1'b0); // wrap store R4 R9
    run_op(1'b0, 4'h5, 16'hFFFF, 16'h0, 1'b0);   // read back across wrap
    run_op(1'b0, 4'h6, 16'h0000, 16'h0, 1'b0);   // next bank untouched R2
    run_op(1'b0, 4'h4, 16'hFFFF, 16'h0, 1'b0);   // previous bank untouched
    run_op(1'b1, 4'h0, 16'h0000, 16'hA55A, 1'b1); // noisy store R7
    run_op(1'b0, 4'h0, 16'h0000, 16'h0, 1'b1);   // noisy load R7
    run_op(1'b0, 4'hF, 16'h8001, 16'h0, 1'b0);
    // back-to-back acceptance with start held high
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b0; bank_i = 4'hA; ptr_i = 16'h7FFF;
    repeat (3 * (BUSY_LEN + 1)) @(negedge clk);
    start_i = 1'b0;
    repeat (2 * BUSY_LEN) @(negedge clk);
    // mid-flight reset R8
    run_op(1'b0, 4'h2, 16'h0100, 16'h0, 1'b0);
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b1; st_data_i = 16'h1357;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && mem_en_o == 1'b0, "R8 reset mid-transfer", int'({busy_o, mem_en_o}), 0);
    chk(ld_data_o == 16'h0, "R8 reset clears load", int'(ld_data_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule